// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a 9-bit first-in first-out buffer. Its write port and its read port run on independent clocks. Its depth is a parameter and defaults to 1024 words. It drives four active-low status outputs: empty, full, almost-empty and almost-full. The almost-empty level `n` and the almost-full level `m` come from four offset registers, which hold the low and high parts of each level.

One shared mode input, `ld`, decides where an enabled access goes. When `ld` is high, a write stores a word in the buffer memory and a read returns the oldest stored word. When `ld` is low, the same enables write or read the offset registers through the data buses. Those registers are visited in a fixed rotating order, and the write side and the read side each keep their own position in it.

The write and read pointers cross between the clock domains as Gray code through two-flop synchronizers. Each flag is computed in the domain that owns it.

Top module: `prog_flag_fifo`

## Requirements
- R1: After reset, `empty_n`=0, `full_n`=1, `almost_empty_n`=0 and `almost_full_n`=1. Both `n` and `m` equal 7, so the four offset registers read back 7, 0, 7, 0.
- R2: When `ld`=0 and `wr_en_n`=0, each rising `wclk` edge loads `din` into the selected offset register. The selection then advances through slot 0 (bits 7:0 of `n`), slot 1 (upper bits of `n`), slot 2 (bits 7:0 of `m`) and slot 3 (upper bits of `m`), and wraps from slot 3 to slot 0. Reset returns it to slot 0.
- R3: The upper-part registers keep only log2(DEPTH)−8 bits, so 2 bits at the default depth. Bits of `din` above that width are dropped.
- R4: When `ld`=0 and `rd_en_n`=0, each rising `rclk` edge puts the selected offset register on `dout`, zero-extended to 9 bits. The selection advances in the R2 order, wraps the same way, and is kept separately from the write-side selection.
- R5: While `wr_en_n`=1, nothing changes on a `wclk` edge whatever the levels of `ld` and `din`. Neither the buffer nor any offset register is modified.
- R6: When `ld`=1 and `wr_en_n`=0, a `wclk` edge stores `din`. When `ld`=1 and `rd_en_n`=0, an `rclk` edge loads the oldest unread word into `dout`. Words leave in the order they were written.
- R7: `empty_n` is low exactly when no unread word is held, once the pointer crossing has settled.
- R8: `full_n` is low exactly when DEPTH unread words are held, once the pointer crossing has settled.
- R9: `almost_empty_n` is a register clocked by `rclk`. It is low while n or fewer words are held and high once n+1 or more are held.
- R10: `almost_full_n` is a register clocked by `wclk`. It is low while DEPTH−m or more words are held and high while more than m locations are free.
- R11: A write while full and a read while empty are ignored. The pointers do not move, and `dout` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ld | input | 1 | 1 routes accesses to the buffer memory, 0 routes them to the offset registers |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_n | input | 1 | Active-low read enable |
| din | input | 9 | Write data or offset value |
| dout | output | 9 | Read data or offset readback |
| empty_n | output | 1 | Low when the buffer is empty |
| full_n | output | 1 | Low when the buffer is full |
| almost_empty_n | output | 1 | Low when n or fewer words are held |
| almost_full_n | output | 1 | Low when DEPTH−m or more words are held |

## Verification
A buffer write on `wclk` and a buffer read on `rclk` can land at the same instant while only a few words are stored, so the read side may be acting on a pointer that is still crossing over. This is provoked by running a writer and a reader concurrently on clocks with unrelated periods. The reader issues a read only when it sees `empty_n` high, and every word it pulls is compared against the written sequence. Once both sides stop, `empty_n` must return low, which shows that no word was lost, repeated or reordered while the two domains raced.

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo #(
  parameter int DEPTH = 1024,
  parameter int W     = 9
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         wr_en_n,
  input  logic         rd_en_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty_n,
  output logic         full_n,
  output logic         almost_empty_n,
  output logic         almost_full_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int MW = AW - 8;
  localparam logic [AW:0] DEP = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0] wbin, rbin, wgray, rgray, wq1, wq2, rq1, rq2;
  logic [7:0]    e_lo, f_lo;
  logic [MW-1:0] e_hi, f_hi;
  logic [1:0]    wsel, rsel;

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  wire [AW-1:0] n_off = {e_hi, e_lo};
  wire [AW-1:0] m_off = {f_hi, f_lo};
  wire [AW:0] wbin_nx = wbin + 1'b1;
  wire [AW:0] rbin_nx = rbin + 1'b1;
  wire [AW:0] wcnt = wbin - g2b(rq2);
  wire [AW:0] rcnt = g2b(wq2) - rbin;
  wire do_wr = !wr_en_n && ld && full_n;
  wire do_rd = !rd_en_n && ld && empty_n;

  assign full_n  = (wgray != {~rq2[AW:AW-1], rq2[AW-2:0]});
  assign empty_n = (rgray != wq2);

  always_ff @(posedge wclk)
    if (do_wr) mem[wbin[AW-1:0]] <= din;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin <= '0; wgray <= '0; rq1 <= '0; rq2 <= '0;
      e_lo <= 8'd7; e_hi <= '0; f_lo <= 8'd7; f_hi <= '0;
      wsel <= '0; almost_full_n <= 1'b1;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      almost_full_n <= (wcnt < DEP - {1'b0, m_off});
      if (do_wr) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
      if (!wr_en_n && !ld) begin
        case (wsel)
          2'd0: e_lo <= din[7:0];
          2'd1: e_hi <= din[MW-1:0];
          2'd2: f_lo <= din[7:0];
          default: f_hi <= din[MW-1:0];
        endcase
        wsel <= wsel + 2'd1;
      end
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0;
      rsel <= '0; dout <= '0; almost_empty_n <= 1'b0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      almost_empty_n <= (rcnt > {1'b0, n_off});
      if (do_rd) begin
        dout  <= mem[rbin[AW-1:0]];
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end else if (!rd_en_n && !ld) begin
        case (rsel)
          2'd0: dout <= W'(e_lo);
          2'd1: dout <= W'(e_hi);
          2'd2: dout <= W'(f_lo);
          default: dout <= W'(f_hi);
        endcase
        rsel <= rsel + 2'd1;
      end
    end
  end
endmodule

module prog_flag_fifo_chk #(parameter int PW = 11) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          empty_n,
  input logic          full_n,
  input logic          almost_empty_n,
  input logic          almost_full_n,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr
);
  // R11
  wr_when_full_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wptr));
  // R11
  rd_when_empty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(rptr));
  // R9
  ae_at_empty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> !almost_empty_n);
  // R10
  af_at_full_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> !almost_full_n);
endmodule

bind prog_flag_fifo prog_flag_fifo_chk #(.PW(AW+1)) chk_i (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .empty_n(empty_n), .full_n(full_n),
  .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n),
  .wptr(wbin), .rptr(rbin)
);

// File: tb/prog_flag_fifo_test.sv
`timescale 1ns/1ps
module prog_flag_fifo_test;
  localparam int DEPTH = 1024;
  logic wclk = 0, rclk = 0, rst_n = 0, ld = 1, wr_en_n = 1, rd_en_n = 1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic empty_n, full_n, almost_empty_n, almost_full_n;
  int checks = 0, fails = 0;

  always #10 wclk = ~wclk;
  always #17 rclk = ~rclk;

  prog_flag_fifo #(.DEPTH(DEPTH)) uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (4) @(negedge wclk);
  endtask

  task automatic wr_off(input logic [8:0] v);
    @(negedge wclk); ld = 0; wr_en_n = 0; din = v;
    @(negedge wclk); wr_en_n = 1; ld = 1;
  endtask

  task automatic rd_off(input int exp, input string req);
    @(negedge rclk); ld = 0; rd_en_n = 0;
    @(negedge rclk); rd_en_n = 1; ld = 1;
    chk(req, dout, exp);
  endtask

  task automatic push(input logic [8:0] v);
    @(negedge wclk); ld = 1; wr_en_n = 0; din = v;
    @(negedge wclk); wr_en_n = 1;
  endtask

  task automatic pop(output logic [8:0] v);
    @(negedge rclk); ld = 1; rd_en_n = 0;
    @(negedge rclk); rd_en_n = 1; v = dout;
  endtask

  task automatic t_reset();
    chk("R1 empty_n", empty_n, 0);
    chk("R1 full_n", full_n, 1);
    chk("R1 almost_empty_n", almost_empty_n, 0);
    chk("R1 almost_full_n", almost_full_n, 1);
    rd_off(7, "R1/R4 slot0");
    rd_off(0, "R1/R4 slot1");
    rd_off(7, "R1/R4 slot2");
    rd_off(0, "R1/R4 slot3");
  endtask

  task automatic t_offsets();
    wr_off(9'h034); wr_off(9'h1FE); wr_off(9'h005); wr_off(9'h000);
    rd_off(9'h034, "R2 slot0");
    rd_off(2, "R3 upper bits masked");
    rd_off(5, "R2 slot2");
    rd_off(0, "R2 slot3");
    wr_off(9'h003); wr_off(0); wr_off(5); wr_off(0);
    rd_off(3, "R2/R4 wrap slot0");
    rd_off(0, "R4 slot1");
    rd_off(5, "R4 slot2");
    rd_off(0, "R4 slot3");
  endtask

  task automatic t_idle();
    for (int i = 0; i < 6; i++) begin
      @(negedge wclk); ld = i[0]; din = 9'h1AB ^ 9'(i); wr_en_n = 1;
    end
    @(negedge wclk); ld = 1;
    settle();
    chk("R5 no write while disabled", empty_n, 0);
    rd_off(3, "R5 slot0 kept");
    rd_off(0, "R5 slot1 kept");
    rd_off(5, "R5 slot2 kept");
    rd_off(0, "R5 slot3 kept");
  endtask

  task automatic t_empty_read();
    logic [8:0] v;
    pop(v);
    chk("R11 read while empty keeps dout", v, 0);
    settle();
    chk("R11 still empty", empty_n, 0);
    push(9'h0C3);
    settle();
    pop(v);
    chk("R11 pointer unchanged after empty read", v, 9'h0C3);
    settle();
    chk("R7 empty again", empty_n, 0);
  endtask

  task automatic t_fill();
    logic [8:0] v;
    for (int k = 1; k <= DEPTH; k++) begin
      push(9'((k * 7 + 3) & 9'h1FF));
      if (k == 1 || k == 3 || k == 4 || k == 1018 || k == 1019 || k == 1023 || k == DEPTH) begin
        settle();
        chk($sformatf("R7 empty_n at %0d", k), empty_n, 1);
        chk($sformatf("R9 almost_empty_n at %0d", k), almost_empty_n, k >= 4);
        chk($sformatf("R10 almost_full_n at %0d", k), almost_full_n, k < 1019);
        chk($sformatf("R8 full_n at %0d", k), full_n, k < DEPTH);
      end
    end
    push(9'h155);
    settle();
    chk("R11 still full", full_n, 0);
    for (int k = 1; k <= DEPTH; k++) begin
      pop(v);
      chk($sformatf("R6 word %0d", k), v, (k * 7 + 3) & 9'h1FF);
    end
    settle();
    chk("R7 empty after drain", empty_n, 0);
    chk("R9 almost_empty_n after drain", almost_empty_n, 0);
    pop(v);
    chk("R11 extra write was dropped", v, (DEPTH * 7 + 3) & 9'h1FF);
  endtask

  task automatic t_race();
    fork
      begin
        for (int k = 0; k < 300; k++) begin
          @(negedge wclk);
          while (!full_n) @(negedge wclk);
          wr_en_n = 0; din = 9'(k) ^ 9'h0AA;
          @(negedge wclk); wr_en_n = 1;
        end
      end
      begin
        int got = 0;
        logic pend = 0;
        while (got < 300) begin
          @(negedge rclk);
          if (pend) begin
            chk($sformatf("R6 concurrent word %0d", got), dout, 9'(got) ^ 9'h0AA);
            got++;
          end
          pend = empty_n && got < 300;
          rd_en_n = !pend;
        end
        rd_en_n = 1;
      end
    join
    settle();
    chk("R7 empty after concurrent run", empty_n, 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge wclk);
    rst_n = 1;
    repeat (2) @(negedge wclk);
    t_reset();
    t_offsets();
    t_idle();
    t_empty_read();
    t_fill();
    t_race();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule